// File: doc/BRIEF.md
# Auto-Power-Down Converter Read Sequencer

This block is the host-side master for one serial 8-bit analog-to-digital converter that wakes on a start pulse and sleeps again once its conversion is done. The host asks for a sample through a request/ready handshake. The sequencer then makes the complete exchange with the converter. It first drives a short high pulse on the conversion-start line, whose falling edge begins the conversion. It then waits a fixed number of system cycles that covers the worst-case conversion time. Last, it produces a burst of eight serial clocks and gathers the returned bits into a byte.

The converter changes its data output on rising serial-clock edges. For this reason the serial clock rests low and the sequencer takes each bit in the cycle of the falling edge. The first bit taken is the most significant one. When the eighth bit is in, the byte appears on the result port together with a one-cycle valid strobe, and the handshake becomes ready again.

All timing is set by compile-time parameters counted in system-clock cycles: the start-pulse width, the wait after the start pulse falls, and the serial-clock half period. A new start pulse can only begin from the idle state, so no start edge can land inside a read burst.

Top module: `adc_read_seq`

## Requirements
- R1: After reset, `req_ready_o` is 1, and `conv_start_o`, `ser_clk_o` and `result_valid_o` are 0.
- R2: A request is accepted on a clock edge where both `req_valid_i` and `req_ready_o` are 1. From the next cycle, `conv_start_o` is high for exactly START_CYC cycles and then returns low.
- R3: The first rising edge of `ser_clk_o` comes exactly WAIT_CYC cycles after `conv_start_o` falls. `conv_start_o` stays low for the whole burst.
- R4: Each read produces exactly NBITS (8) serial-clock pulses. Each pulse is high for HALF_CYC cycles and low for HALF_CYC cycles. `ser_clk_o` is low whenever no burst is running.
- R5: `ser_data_i` is sampled in the cycle in which `ser_clk_o` goes from high to low. The first sample becomes bit 7 of `result_o` and the last becomes bit 0 (MSB first).
- R6: `result_valid_o` is high for exactly one cycle, and that cycle comes directly after the last low phase. The total time from acceptance to the valid cycle is START_CYC + WAIT_CYC + 2·NBITS·HALF_CYC + 1 cycles, and `result_o` holds the byte in that cycle.
- R7: `req_ready_o` is 0 from the cycle after acceptance through the valid cycle. It is 1 again in the cycle after the valid strobe.
- R8: A request raised while `req_ready_o` is 0 has no effect. If it is dropped before ready returns, no further start pulse follows and `result_o` keeps the finished byte.
- R9: A rising edge of `conv_start_o` only follows an accepted request with the serial clock low. With a request held high, the next read starts in the cycle after the valid strobe, and that read is again complete and correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Sample request |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| conv_start_o | output | 1 | Conversion-start pulse to the converter |
| ser_clk_o | output | 1 | Serial clock to the converter, rests low |
| ser_data_i | input | 1 | Serial data from the converter |
| result_o | output | 8 | Assembled sample |
| result_valid_o | output | 1 | One-cycle strobe, result_o is valid |

## Verification
Two events can meet in the same cycle. A request can arrive while the sequencer is busy, and it can be held high through the valid strobe so that the next acceptance comes in the cycle right after the strobe. Both cases are provoked directly. In one, the request is raised during the conversion wait and then dropped. The bench then checks that no start pulse follows and that the result byte does not change. In the other, the request is kept high across two reads. The bench checks that the second read's start pulse begins only after the strobe and that both reads return their own bytes with the exact phase lengths.

// File: rtl/adc_read_seq_pkg.sv
package adc_read_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PULSE = 3'd1,
        ST_WAIT  = 3'd2,
        ST_SHIFT = 3'd3,
        ST_DONE  = 3'd4
    } seq_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R2/R3/R4: every phase length starts from the loaded value
    assert_timer_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (cnt_q == $past(load_val_i)));

    assert_timer_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter #(
    parameter int NBITS = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [NBITS-1:0] data_o
);
    logic [NBITS-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (shift_i) begin
            data_d = {data_q[NBITS-2:0], bit_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) data_q <= '0;
        else         data_q <= data_d;
    end

    assign data_o = data_q;

    // R5: the sampled bit enters at the low end, earlier bits move toward the MSB
    assert_shift_in_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_i |=> (data_q[0] == $past(bit_i)) && (data_q[NBITS-1:1] == $past(data_q[NBITS-2:0])));

    assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !shift_i |=> $stable(data_q));

endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq
    import adc_read_seq_pkg::*;
#(
    parameter int START_CYC = 3,
    parameter int WAIT_CYC  = 20,
    parameter int HALF_CYC  = 2,
    parameter int NBITS     = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    output logic             conv_start_o,
    output logic             ser_clk_o,
    input  logic             ser_data_i,
    output logic [NBITS-1:0] result_o,
    output logic             result_valid_o
);
    localparam int MAX_CYC = max3(START_CYC, WAIT_CYC, HALF_CYC);
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam int BIT_W   = $clog2(NBITS + 1);

    localparam logic [CNT_W-1:0] START_LD = CNT_W'(START_CYC - 1);
    localparam logic [CNT_W-1:0] WAIT_LD  = CNT_W'(WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(HALF_CYC - 1);
    localparam logic [BIT_W-1:0] BITS_END = BIT_W'(NBITS);

    typedef struct packed {
        seq_state_e       state;
        logic             sclk;
        logic [BIT_W-1:0] bit_cnt;
    } seq_regs_t;

    seq_regs_t        r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             shift_en;

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        shift_en = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid_i) begin
                    r_d.state = ST_PULSE;
                    tmr_load  = 1'b1;
                    tmr_val   = START_LD;
                end
            end
            ST_PULSE: begin
                if (tmr_zero) begin
                    r_d.state = ST_WAIT;
                    tmr_load  = 1'b1;
                    tmr_val   = WAIT_LD;
                end
            end
            ST_WAIT: begin
                if (tmr_zero) begin
                    r_d.state   = ST_SHIFT;
                    r_d.sclk    = 1'b1;
                    r_d.bit_cnt = '0;
                    tmr_load    = 1'b1;
                    tmr_val     = HALF_LD;
                end
            end
            ST_SHIFT: begin
                if (tmr_zero) begin
                    if (r_q.sclk) begin
                        r_d.sclk    = 1'b0;
                        r_d.bit_cnt = r_q.bit_cnt + 1'b1;
                        shift_en    = 1'b1;
                        tmr_load    = 1'b1;
                        tmr_val     = HALF_LD;
                    end else if (r_q.bit_cnt == BITS_END) begin
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.sclk = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = HALF_LD;
                    end
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.sclk  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state   <= ST_IDLE;
            r_q.sclk    <= 1'b0;
            r_q.bit_cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    adc_seq_timer #(.CNT_W(CNT_W)) i_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    adc_seq_shifter #(.NBITS(NBITS)) i_shifter (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .shift_i (shift_en),
        .bit_i   (ser_data_i),
        .data_o  (result_o)
    );

    assign req_ready_o    = (r_q.state == ST_IDLE);
    assign conv_start_o   = (r_q.state == ST_PULSE);
    assign ser_clk_o      = r_q.sclk;
    assign result_valid_o = (r_q.state == ST_DONE);

    // R9: a start edge needs an accepted request and a quiet serial clock
    assert_start_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(conv_start_o) |-> $past(req_valid_i) && $past(req_ready_o) && !$past(ser_clk_o));

    // R3: serial clock never runs while the start pulse is high
    assert_no_overlap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(conv_start_o && ser_clk_o));

    // R6: the valid strobe lasts a single cycle
    assert_valid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        result_valid_o |=> !result_valid_o);

    // R7: ready stays low through the strobe and returns right after it
    assert_ready_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        result_valid_o |-> !req_ready_o ##1 req_ready_o);

    // R4: the burst never counts past the byte width
    assert_bit_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.bit_cnt <= BITS_END);

    // R4: the serial clock is low whenever the sequencer is idle
    assert_sclk_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_ready_o |-> !ser_clk_o);

endmodule

// File: tb/test_adc_read_seq.sv
module test_adc_read_seq;
    localparam int SH   = 3;
    localparam int CW   = 20;
    localparam int HALF = 2;
    localparam int NB   = 8;
    localparam int TOTAL = SH + CW + 2 * NB * HALF + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       conv_start;
    logic       ser_clk;
    logic       ser_data = 1'b0;
    logic [7:0] result;
    logic       result_valid;

    int tests = 0;
    int fails = 0;

    logic [7:0] dev_byte = 8'h00;
    int         dev_idx  = 0;

    always #5 clk = ~clk;

    adc_read_seq #(.START_CYC(SH), .WAIT_CYC(CW), .HALF_CYC(HALF), .NBITS(NB)) i_adc_read_seq (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .req_valid_i    (req_valid),
        .req_ready_o    (req_ready),
        .conv_start_o   (conv_start),
        .ser_clk_o      (ser_clk),
        .ser_data_i     (ser_data),
        .result_o       (result),
        .result_valid_o (result_valid)
    );

    // converter model: next bit appears shortly after each rising serial clock
    always @(posedge ser_clk) begin
        #1;
        if (dev_idx < 8) ser_data = dev_byte[7 - dev_idx];
        dev_idx = dev_idx + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        check(conv_start == 1'b0, "R1 start", int'(conv_start), 0);
        check(ser_clk == 1'b0, "R1 sclk", int'(ser_clk), 0);
        check(result_valid == 1'b0, "R1 valid", int'(result_valid), 0);
    endtask

    // one read; hold keeps the request high, poke raises a request while busy
    task automatic do_read(input logic [7:0] pat, input bit hold, input bit poke);
        int  cyc = 0, hi = 0, gap = 0, rises = 0, highs = 0, rdy_bad = 0, start_in_burst = 0;
        bit  prev_sclk = 1'b0, got = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R7 ready after strobe", int'(req_ready), 1);
        check(result_valid == 1'b0, "R6 single-cycle strobe", int'(result_valid), 0);
        dev_byte = pat;
        dev_idx  = 0;
        ser_data = ~pat[7];
        req_valid = 1'b1;
        while (!got && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            if (!hold && !poke) req_valid = 1'b0;
            if (poke) req_valid = (cyc >= SH + 2 && cyc < SH + 6);
            if (conv_start) hi++;
            if (!conv_start && !ser_clk && rises == 0 && hi > 0) gap++;
            if (ser_clk && !prev_sclk) rises++;
            if (ser_clk) highs++;
            if (conv_start && rises > 0) start_in_burst++;
            if (req_ready) rdy_bad++;
            prev_sclk = ser_clk;
            if (result_valid) got = 1'b1;
        end
        if (poke) req_valid = 1'b0;
        check(hi == SH, "R2 start width", hi, SH);
        check(gap == CW, "R3 wait before burst", gap, CW);
        check(rises == NB, "R4 pulse count", rises, NB);
        check(highs == NB * HALF, "R4 high time", highs, NB * HALF);
        check(cyc == TOTAL, "R6 latency", cyc, TOTAL);
        check(result == pat, "R5 MSB-first byte", int'(result), int'(pat));
        check(rdy_bad == 0, "R7 ready low while busy", rdy_bad, 0);
        check(start_in_burst == 0, "R9 no start in burst", start_in_burst, 0);
    endtask

    task automatic t_basic();
        do_read(8'hA5, 1'b0, 1'b0);
        do_read(8'h00, 1'b0, 1'b0);
        do_read(8'hFF, 1'b0, 1'b0);
        do_read(8'h81, 1'b0, 1'b0);
    endtask

    task automatic t_busy_ignored();
        logic [7:0] held;
        int starts = 0, notready = 0;
        do_read(8'h3C, 1'b0, 1'b1);
        held = result;
        repeat (3 * (SH + CW)) begin
            @(negedge clk);
            if (conv_start) starts++;
            if (!req_ready) notready++;
        end
        check(starts == 0, "R8 no start after busy request", starts, 0);
        check(notready == 0, "R8 stays idle", notready, 0);
        check(result == held, "R8 result kept", int'(result), int'(held));
    endtask

    task automatic t_back_to_back();
        do_read(8'h5A, 1'b1, 1'b0);
        do_read(8'hC3, 1'b0, 1'b0);
        @(negedge clk);
        check(req_ready == 1'b1, "R9 idle after chained reads", int'(req_ready), 1);
    endtask

    initial begin
        #2_000_000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual 0 expected 1 (run completed)");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_busy_ignored();
        t_back_to_back();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule